// File: doc/BRIEF.md
# Thread-Tagged Multiport Register File

This block is the register state of one processing element that runs several independent data threads in an interleaved way. Each thread owns a private set of 32-bit registers. Every access carries a thread tag next to its register address, so the threads share one physical array and never see each other's contents. The arithmetic unit has its own read ports and a write port. Four further read/write lanes are shared by two kinds of traffic.

In link mode, each lane serves one 32-bit bidirectional neighbour connection and has its own tag, address and write enable. In memory mode, the four lanes act together as one 128-bit local-memory port. They reach four consecutive registers of one thread in a single cycle. Reads are combinational and pass through any write to the same register and thread in the same cycle. Writes land on the next rising clock edge. When writes collide, fixed priority decides which one lands.

Top module: `rf_thread_regfile`

## Requirements
- R1: While reset is asserted, and right after it is released, every register of every thread reads as zero.
- R2: A write on the arithmetic-unit port stores 32 bits into register `alu_wr_addr` of thread `alu_wr_thr` at the next rising edge. Each of the arithmetic unit's read ports then returns that value independently.
- R3: A write tagged with one thread never changes the register with the same address in any other thread.
- R4: With `mem_en` low, lane k writes `link_wdata[k]` when `link_we[k]` is high. Lane k's read data comes from register `link_addr[k]` of thread `link_thr[k]`. All four lanes act in the same cycle.
- R5: With `mem_en` and `mem_we` high, lane k writes bits [32k+31:32k] of `mem_wdata` into register (`mem_addr` + k) modulo 16 of thread `mem_thr`. The low 32 bits go to register `mem_addr`.
- R6: With `mem_en` high, `mem_rdata` bits [32k+31:32k] hold register (`mem_addr` + k) modulo 16 of thread `mem_thr`.
- R7: A read in the same cycle as a write to the same register and thread returns the data being written. This holds for every read port and for `mem_rdata`.
- R8: When the arithmetic-unit write and a lane write hit the same register and thread in one cycle, the arithmetic-unit data is stored and bypassed.
- R9: When two link lanes write the same register and thread in one cycle, the lane with the lower index wins.
- R10: While `mem_en` is high, `link_we` has no effect. A memory-mode read cycle with no arithmetic-unit write leaves all registers unchanged.
- R11: With every write enable low, no register changes, whatever the write data and addresses are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| alu_rd_thr | input | 3x2 | Thread tag per arithmetic read port |
| alu_rd_addr | input | 3x4 | Register address per arithmetic read port |
| alu_rd_data | output | 3x32 | Read data per arithmetic read port |
| alu_wr_en | input | 1 | Arithmetic write enable |
| alu_wr_thr | input | 2 | Arithmetic write thread tag |
| alu_wr_addr | input | 4 | Arithmetic write register address |
| alu_wr_data | input | 32 | Arithmetic write data |
| link_we | input | 4 | Per-lane write enable in link mode |
| link_thr | input | 4x2 | Per-lane thread tag in link mode |
| link_addr | input | 4x4 | Per-lane register address in link mode |
| link_wdata | input | 4x32 | Per-lane write data in link mode |
| link_rdata | output | 4x32 | Per-lane read data |
| mem_en | input | 1 | Selects memory mode for all four lanes |
| mem_we | input | 1 | Memory-mode write enable |
| mem_thr | input | 2 | Memory-mode thread tag |
| mem_addr | input | 4 | Memory-mode base register address |
| mem_wdata | input | 128 | Memory-mode write word |
| mem_rdata | output | 128 | Memory-mode read word |

## Verification
Two functions can fall in the same cycle: a write and a read of the same register and thread, and two writes from different sources to one register. The bench provokes both by driving the colliding accesses before an edge. It judges the bypassed read data combinationally before that edge. After the edge it reads the stored value back to confirm the winner: the arithmetic unit over a lane, and lane 0 over lane 3. The memory-mode path is also driven with the link write enables all high, to show that they have no effect.

// File: rtl/rf_pkg.sv
package rf_pkg;
   localparam int unsigned DEF_THREADS = 4;
   localparam int unsigned DEF_REGS    = 16;
   localparam int unsigned DEF_WIDTH   = 32;
   localparam int unsigned DEF_LANES   = 4;
   localparam int unsigned DEF_ALU_RD  = 3;

   typedef enum logic {
      LANE_LINK = 1'b0,
      LANE_MEM  = 1'b1
   } lane_mode_e;
endpackage

// File: rtl/rf_lane_mux.sv
module rf_lane_mux
   import rf_pkg::*;
#(
   parameter int unsigned NUM_THREADS = DEF_THREADS,
   parameter int unsigned NUM_REGS    = DEF_REGS,
   parameter int unsigned WIDTH       = DEF_WIDTH,
   parameter int unsigned LANES       = DEF_LANES,
   localparam int unsigned TW = $clog2(NUM_THREADS),
   localparam int unsigned AW = $clog2(NUM_REGS)
)(
   input  logic [LANES-1:0]                link_we,
   input  logic [LANES-1:0][TW-1:0]        link_thr,
   input  logic [LANES-1:0][AW-1:0]        link_addr,
   input  logic [LANES-1:0][WIDTH-1:0]     link_wdata,
   input  logic                            mem_en,
   input  logic                            mem_we,
   input  logic [TW-1:0]                   mem_thr,
   input  logic [AW-1:0]                   mem_addr,
   input  logic [LANES*WIDTH-1:0]          mem_wdata,
   output logic [LANES-1:0]                lane_we,
   output logic [LANES-1:0][TW-1:0]        lane_thr,
   output logic [LANES-1:0][AW-1:0]        lane_addr,
   output logic [LANES-1:0][WIDTH-1:0]     lane_wdata
);
   lane_mode_e mode;

   assign mode = mem_en ? LANE_MEM : LANE_LINK;

   // Memory mode spreads one wide word over consecutive registers; the
   // address wraps within the thread because AW bits drop the carry.
   always_comb begin
      for (int k = 0; k < LANES; k++) begin
         if (mode == LANE_MEM) begin
            lane_we[k]    = mem_we;
            lane_thr[k]   = mem_thr;
            lane_addr[k]  = mem_addr + AW'(k);
            lane_wdata[k] = mem_wdata[k*WIDTH +: WIDTH];
         end else begin
            lane_we[k]    = link_we[k];
            lane_thr[k]   = link_thr[k];
            lane_addr[k]  = link_addr[k];
            lane_wdata[k] = link_wdata[k];
         end
      end
   end
endmodule

// File: rtl/rf_bank_array.sv
module rf_bank_array
   import rf_pkg::*;
#(
   parameter int unsigned NUM_THREADS = DEF_THREADS,
   parameter int unsigned NUM_REGS    = DEF_REGS,
   parameter int unsigned WIDTH       = DEF_WIDTH,
   parameter int unsigned NWR         = DEF_LANES + 1,
   localparam int unsigned TW = $clog2(NUM_THREADS),
   localparam int unsigned AW = $clog2(NUM_REGS)
)(
   input  logic                                          clk,
   input  logic                                          rst_n,
   input  logic [NWR-1:0]                                req_we,
   input  logic [NWR-1:0][TW-1:0]                        req_thr,
   input  logic [NWR-1:0][AW-1:0]                        req_addr,
   input  logic [NWR-1:0][WIDTH-1:0]                     req_data,
   output logic [NUM_THREADS-1:0][NUM_REGS-1:0][WIDTH-1:0] bank_q
);
   // Requests arrive in priority order: index 0 is the strongest.
   for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
      for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
         logic             hit;
         logic [WIDTH-1:0] nxt;
         logic [WIDTH-1:0] q;

         always_comb begin
            hit = 1'b0;
            nxt = q;
            for (int i = NWR - 1; i >= 0; i--) begin
               if (req_we[i] && req_thr[i] == TW'(t) && req_addr[i] == AW'(r)) begin
                  hit = 1'b1;
                  nxt = req_data[i];
               end
            end
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   q <= '0;
            else if (hit) q <= nxt;
         end

         assign bank_q[t][r] = q;
      end
   end
endmodule

// File: rtl/rf_read_port.sv
module rf_read_port
   import rf_pkg::*;
#(
   parameter int unsigned NUM_THREADS = DEF_THREADS,
   parameter int unsigned NUM_REGS    = DEF_REGS,
   parameter int unsigned WIDTH       = DEF_WIDTH,
   parameter int unsigned NWR         = DEF_LANES + 1,
   localparam int unsigned TW = $clog2(NUM_THREADS),
   localparam int unsigned AW = $clog2(NUM_REGS)
)(
   input  logic [TW-1:0]                                 rd_thr,
   input  logic [AW-1:0]                                 rd_addr,
   input  logic [NUM_THREADS-1:0][NUM_REGS-1:0][WIDTH-1:0] bank_q,
   input  logic [NWR-1:0]                                req_we,
   input  logic [NWR-1:0][TW-1:0]                        req_thr,
   input  logic [NWR-1:0][AW-1:0]                        req_addr,
   input  logic [NWR-1:0][WIDTH-1:0]                     req_data,
   output logic [WIDTH-1:0]                              rd_data
);
   // Same-cycle write data overrides stored data, with the same priority
   // that the storage applies, so read and stored values always agree.
   always_comb begin
      rd_data = bank_q[rd_thr][rd_addr];
      for (int i = NWR - 1; i >= 0; i--) begin
         if (req_we[i] && req_thr[i] == rd_thr && req_addr[i] == rd_addr)
            rd_data = req_data[i];
      end
   end
endmodule

// File: rtl/rf_thread_regfile.sv
module rf_thread_regfile
   import rf_pkg::*;
#(
   parameter int unsigned NUM_THREADS = DEF_THREADS,
   parameter int unsigned NUM_REGS    = DEF_REGS,
   parameter int unsigned WIDTH       = DEF_WIDTH,
   parameter int unsigned LANES       = DEF_LANES,
   parameter int unsigned ALU_RD      = DEF_ALU_RD,
   localparam int unsigned TW    = $clog2(NUM_THREADS),
   localparam int unsigned AW    = $clog2(NUM_REGS),
   localparam int unsigned MEM_W = LANES * WIDTH
)(
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic [ALU_RD-1:0][TW-1:0]         alu_rd_thr,
   input  logic [ALU_RD-1:0][AW-1:0]         alu_rd_addr,
   output logic [ALU_RD-1:0][WIDTH-1:0]      alu_rd_data,
   input  logic                              alu_wr_en,
   input  logic [TW-1:0]                     alu_wr_thr,
   input  logic [AW-1:0]                     alu_wr_addr,
   input  logic [WIDTH-1:0]                  alu_wr_data,
   input  logic [LANES-1:0]                  link_we,
   input  logic [LANES-1:0][TW-1:0]          link_thr,
   input  logic [LANES-1:0][AW-1:0]          link_addr,
   input  logic [LANES-1:0][WIDTH-1:0]       link_wdata,
   output logic [LANES-1:0][WIDTH-1:0]       link_rdata,
   input  logic                              mem_en,
   input  logic                              mem_we,
   input  logic [TW-1:0]                     mem_thr,
   input  logic [AW-1:0]                     mem_addr,
   input  logic [MEM_W-1:0]                  mem_wdata,
   output logic [MEM_W-1:0]                  mem_rdata
);
   localparam int unsigned NWR = LANES + 1;

   initial begin
      if (NUM_THREADS < 2 || (NUM_THREADS & (NUM_THREADS - 1)) != 0)
         $fatal(1, "thread count must be a power of two of at least 2");
      if (NUM_REGS < 2 || (NUM_REGS & (NUM_REGS - 1)) != 0)
         $fatal(1, "register count must be a power of two of at least 2");
      if (LANES < 1 || LANES > NUM_REGS)
         $fatal(1, "lane count must lie between 1 and the register count");
      if (ALU_RD < 1 || WIDTH < 1)
         $fatal(1, "need at least one arithmetic read port and a nonzero width");
   end

   logic [LANES-1:0]            lane_we;
   logic [LANES-1:0][TW-1:0]    lane_thr;
   logic [LANES-1:0][AW-1:0]    lane_addr;
   logic [LANES-1:0][WIDTH-1:0] lane_wdata;
   logic [LANES-1:0][WIDTH-1:0] lane_rdata;

   logic [NWR-1:0]              req_we;
   logic [NWR-1:0][TW-1:0]      req_thr;
   logic [NWR-1:0][AW-1:0]      req_addr;
   logic [NWR-1:0][WIDTH-1:0]   req_data;

   logic [NUM_THREADS-1:0][NUM_REGS-1:0][WIDTH-1:0] bank_q;

   rf_lane_mux #(
      .NUM_THREADS(NUM_THREADS), .NUM_REGS(NUM_REGS),
      .WIDTH(WIDTH), .LANES(LANES)
   ) u_lane_mux (
      .link_we(link_we), .link_thr(link_thr), .link_addr(link_addr),
      .link_wdata(link_wdata),
      .mem_en(mem_en), .mem_we(mem_we), .mem_thr(mem_thr),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .lane_we(lane_we), .lane_thr(lane_thr), .lane_addr(lane_addr),
      .lane_wdata(lane_wdata)
   );

   // Priority order: arithmetic unit first, then lanes by ascending index.
   always_comb begin
      req_we[0]   = alu_wr_en;
      req_thr[0]  = alu_wr_thr;
      req_addr[0] = alu_wr_addr;
      req_data[0] = alu_wr_data;
      for (int k = 0; k < LANES; k++) begin
         req_we[k+1]   = lane_we[k];
         req_thr[k+1]  = lane_thr[k];
         req_addr[k+1] = lane_addr[k];
         req_data[k+1] = lane_wdata[k];
      end
   end

   rf_bank_array #(
      .NUM_THREADS(NUM_THREADS), .NUM_REGS(NUM_REGS),
      .WIDTH(WIDTH), .NWR(NWR)
   ) u_bank (
      .clk(clk), .rst_n(rst_n),
      .req_we(req_we), .req_thr(req_thr), .req_addr(req_addr),
      .req_data(req_data), .bank_q(bank_q)
   );

   for (genvar p = 0; p < ALU_RD; p++) begin : g_alu_rd
      rf_read_port #(
         .NUM_THREADS(NUM_THREADS), .NUM_REGS(NUM_REGS),
         .WIDTH(WIDTH), .NWR(NWR)
      ) u_rd (
         .rd_thr(alu_rd_thr[p]), .rd_addr(alu_rd_addr[p]), .bank_q(bank_q),
         .req_we(req_we), .req_thr(req_thr), .req_addr(req_addr),
         .req_data(req_data), .rd_data(alu_rd_data[p])
      );
   end

   for (genvar k = 0; k < LANES; k++) begin : g_lane_rd
      rf_read_port #(
         .NUM_THREADS(NUM_THREADS), .NUM_REGS(NUM_REGS),
         .WIDTH(WIDTH), .NWR(NWR)
      ) u_rd (
         .rd_thr(lane_thr[k]), .rd_addr(lane_addr[k]), .bank_q(bank_q),
         .req_we(req_we), .req_thr(req_thr), .req_addr(req_addr),
         .req_data(req_data), .rd_data(lane_rdata[k])
      );
      assign link_rdata[k]              = lane_rdata[k];
      assign mem_rdata[k*WIDTH +: WIDTH] = lane_rdata[k];
   end
endmodule

// File: rtl/rf_thread_regfile_chk.sv
module rf_thread_regfile_chk #(
   parameter int unsigned NUM_THREADS = 4,
   parameter int unsigned NUM_REGS    = 16,
   parameter int unsigned WIDTH       = 32,
   localparam int unsigned TW = $clog2(NUM_THREADS),
   localparam int unsigned AW = $clog2(NUM_REGS)
)(
   input logic                                           clk,
   input logic                                           rst_n,
   input logic [TW-1:0]                                  rd0_thr,
   input logic [AW-1:0]                                  rd0_addr,
   input logic [WIDTH-1:0]                               rd0_data,
   input logic                                           alu_wr_en,
   input logic [TW-1:0]                                  alu_wr_thr,
   input logic [AW-1:0]                                  alu_wr_addr,
   input logic [WIDTH-1:0]                               alu_wr_data,
   input logic                                           mem_en,
   input logic                                           mem_we,
   input logic [TW-1:0]                                  mem_thr,
   input logic [AW-1:0]                                  mem_addr,
   input logic [WIDTH-1:0]                               mem_wdata_lo,
   input logic [NUM_THREADS-1:0][NUM_REGS-1:0][WIDTH-1:0] bank_q
);
   AST_RESET_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (bank_q == '0)); // R1

   AST_ALU_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      alu_wr_en |=> (bank_q[$past(alu_wr_thr)][$past(alu_wr_addr)] == $past(alu_wr_data))); // R8

   AST_READ_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
      (alu_wr_en && rd0_thr == alu_wr_thr && rd0_addr == alu_wr_addr)
      |-> (rd0_data == alu_wr_data)); // R7

   AST_WIDE_LOW_WORD: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_en && mem_we && !(alu_wr_en && alu_wr_thr == mem_thr && alu_wr_addr == mem_addr))
      |=> (bank_q[$past(mem_thr)][$past(mem_addr)] == $past(mem_wdata_lo))); // R5

   AST_WIDE_READ_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_en && !mem_we && !alu_wr_en) |=> (bank_q == $past(bank_q))); // R10
endmodule

bind rf_thread_regfile rf_thread_regfile_chk #(
   .NUM_THREADS(NUM_THREADS), .NUM_REGS(NUM_REGS), .WIDTH(WIDTH)
) u_chk (
   .clk(clk), .rst_n(rst_n),
   .rd0_thr(alu_rd_thr[0]), .rd0_addr(alu_rd_addr[0]), .rd0_data(alu_rd_data[0]),
   .alu_wr_en(alu_wr_en), .alu_wr_thr(alu_wr_thr), .alu_wr_addr(alu_wr_addr),
   .alu_wr_data(alu_wr_data),
   .mem_en(mem_en), .mem_we(mem_we), .mem_thr(mem_thr), .mem_addr(mem_addr),
   .mem_wdata_lo(mem_wdata[WIDTH-1:0]),
   .bank_q(bank_q)
);

// File: tb/rf_thread_regfile_tb.sv
`timescale 1ns/1ps
module rf_thread_regfile_tb;
   localparam int T = 4, R = 16, W = 32, L = 4, NRD = 3;

   logic clk = 1'b0;
   logic rst_n;
   logic [NRD-1:0][1:0]  alu_rd_thr;
   logic [NRD-1:0][3:0]  alu_rd_addr;
   logic [NRD-1:0][31:0] alu_rd_data;
   logic                 alu_wr_en;
   logic [1:0]           alu_wr_thr;
   logic [3:0]           alu_wr_addr;
   logic [31:0]          alu_wr_data;
   logic [L-1:0]         link_we;
   logic [L-1:0][1:0]    link_thr;
   logic [L-1:0][3:0]    link_addr;
   logic [L-1:0][31:0]   link_wdata;
   logic [L-1:0][31:0]   link_rdata;
   logic                 mem_en, mem_we;
   logic [1:0]           mem_thr;
   logic [3:0]           mem_addr;
   logic [127:0]         mem_wdata;
   logic [127:0]         mem_rdata;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   rf_thread_regfile #(.NUM_THREADS(T), .NUM_REGS(R), .WIDTH(W), .LANES(L), .ALU_RD(NRD)) u_dut (
      .clk(clk), .rst_n(rst_n),
      .alu_rd_thr(alu_rd_thr), .alu_rd_addr(alu_rd_addr), .alu_rd_data(alu_rd_data),
      .alu_wr_en(alu_wr_en), .alu_wr_thr(alu_wr_thr), .alu_wr_addr(alu_wr_addr),
      .alu_wr_data(alu_wr_data),
      .link_we(link_we), .link_thr(link_thr), .link_addr(link_addr),
      .link_wdata(link_wdata), .link_rdata(link_rdata),
      .mem_en(mem_en), .mem_we(mem_we), .mem_thr(mem_thr), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
   );

   // Vector table: {thread, address, data}; every pair is unique.
   localparam logic [37:0] VEC [0:7] = '{
      {2'd0, 4'd5,  32'h1111_0005},
      {2'd1, 4'd5,  32'h2222_0005},
      {2'd2, 4'd5,  32'h3333_0005},
      {2'd3, 4'd5,  32'h4444_0005},
      {2'd0, 4'd0,  32'hA5A5_0000},
      {2'd3, 4'd15, 32'hFFFF_000F},
      {2'd1, 4'd9,  32'h0BAD_0009},
      {2'd2, 4'd12, 32'h0000_0001}
   };

   task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic idle();
      alu_wr_en = 1'b0; alu_wr_thr = '0; alu_wr_addr = '0; alu_wr_data = '0;
      link_we = '0; link_thr = '0; link_addr = '0; link_wdata = '0;
      mem_en = 1'b0; mem_we = 1'b0; mem_thr = '0; mem_addr = '0; mem_wdata = '0;
      alu_rd_thr = '0; alu_rd_addr = '0;
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic peek(input int p, input logic [1:0] t, input logic [3:0] a,
                       input logic [31:0] exp, input string req);
      alu_rd_thr[p] = t;
      alu_rd_addr[p] = a;
      #1;
      chk(req, {96'd0, alu_rd_data[p]}, {96'd0, exp});
   endtask

   initial begin
      idle();
      rst_n = 1'b0;
      repeat (3) tick();
      // R1: every register zero in reset
      for (int t = 0; t < T; t++)
         for (int a = 0; a < R; a += 5)
            peek(0, 2'(t), 4'(a), 32'h0, "R1 reset state");
      rst_n = 1'b1;
      tick();
      peek(1, 2'd3, 4'd15, 32'h0, "R1 after release");

      // R2/R3: walk the vector table through the arithmetic write port
      for (int v = 0; v < 8; v++) begin
         alu_wr_en = 1'b1;
         {alu_wr_thr, alu_wr_addr, alu_wr_data} = VEC[v];
         tick();
      end
      idle();
      tick();
      for (int v = 0; v < 8; v++)
         peek(v % NRD, VEC[v][37:36], VEC[v][35:32], VEC[v][31:0], "R2 R3 table readback");
      peek(0, 2'd1, 4'd0, 32'h0, "R3 other thread untouched");
      peek(1, 2'd0, 4'd9, 32'h0, "R3 other thread untouched");

      // R4: four independent link writes in one cycle
      tick();
      link_we = 4'hF;
      for (int k = 0; k < L; k++) begin
         link_thr[k] = 2'(k);
         link_addr[k] = 4'(k + 2);
         link_wdata[k] = 32'hC0DE_0000 + 32'(k);
      end
      tick();
      link_we = '0;
      #1;
      for (int k = 0; k < L; k++)
         chk("R4 link lane readback", {96'd0, link_rdata[k]}, {96'd0, 32'hC0DE_0000 + 32'(k)});

      // R5/R7: wide write with wrap, bypassed on mem_rdata in the same cycle
      idle();
      tick();
      mem_en = 1'b1; mem_we = 1'b1; mem_thr = 2'd2; mem_addr = 4'd14;
      mem_wdata = 128'h4444_4444_3333_3333_2222_2222_1111_1111;
      #1;
      chk("R7 wide write bypass", mem_rdata, 128'h4444_4444_3333_3333_2222_2222_1111_1111);
      tick();
      idle();
      peek(0, 2'd2, 4'd14, 32'h1111_1111, "R5 lane0 low word");
      peek(1, 2'd2, 4'd15, 32'h2222_2222, "R5 lane1");
      peek(2, 2'd2, 4'd0,  32'h3333_3333, "R5 lane2");
      peek(0, 2'd2, 4'd1,  32'h4444_4444, "R5 lane3 wraps");
      peek(1, 2'd3, 4'd14, 32'h0, "R3 wide write isolated");
      peek(2, 2'd2, 4'd12, 32'h0000_0001, "R5 neighbour untouched");

      // R6: wide read
      tick();
      mem_en = 1'b1; mem_thr = 2'd2; mem_addr = 4'd14;
      #1;
      chk("R6 wide read", mem_rdata, 128'h4444_4444_3333_3333_2222_2222_1111_1111);

      // R7: arithmetic write and link write bypass to reads
      idle();
      tick();
      alu_wr_en = 1'b1; alu_wr_thr = 2'd1; alu_wr_addr = 4'd3; alu_wr_data = 32'hBEEF_0103;
      link_we[2] = 1'b1; link_thr[2] = 2'd0; link_addr[2] = 4'd7; link_wdata[2] = 32'h7777_0007;
      peek(1, 2'd1, 4'd3, 32'hBEEF_0103, "R7 alu write bypass");
      peek(2, 2'd0, 4'd7, 32'h7777_0007, "R7 link write bypass");
      tick();
      idle();
      peek(0, 2'd0, 4'd7, 32'h7777_0007, "R7 link write stored");

      // R8: arithmetic unit beats a lane
      tick();
      alu_wr_en = 1'b1; alu_wr_thr = 2'd0; alu_wr_addr = 4'd4; alu_wr_data = 32'hAAAA_0004;
      link_we[1] = 1'b1; link_thr[1] = 2'd0; link_addr[1] = 4'd4; link_wdata[1] = 32'hBBBB_0004;
      peek(0, 2'd0, 4'd4, 32'hAAAA_0004, "R8 priority bypass");
      tick();
      idle();
      peek(0, 2'd0, 4'd4, 32'hAAAA_0004, "R8 priority stored");

      // R9: lane 0 beats lane 3
      tick();
      link_we = 4'b1001;
      link_thr[0] = 2'd3; link_addr[0] = 4'd8; link_wdata[0] = 32'h0000_0008;
      link_thr[3] = 2'd3; link_addr[3] = 4'd8; link_wdata[3] = 32'h3333_0008;
      peek(1, 2'd3, 4'd8, 32'h0000_0008, "R9 lane priority bypass");
      tick();
      idle();
      peek(1, 2'd3, 4'd8, 32'h0000_0008, "R9 lane priority stored");

      // R10: link write enables ignored in memory mode
      tick();
      mem_en = 1'b1; mem_we = 1'b0; mem_thr = 2'd0; mem_addr = 4'd10;
      link_we = 4'hF;
      for (int k = 0; k < L; k++) begin
         link_thr[k] = 2'd0;
         link_addr[k] = 4'(10 + k);
         link_wdata[k] = 32'hDEAD_0000 + 32'(k);
      end
      #1;
      chk("R10 no link bypass in memory mode", mem_rdata, 128'h0);
      tick();
      idle();
      for (int k = 0; k < L; k++)
         peek(k % NRD, 2'd0, 4'(10 + k), 32'h0, "R10 link write ignored");

      // R11: data present but enables low
      tick();
      alu_wr_thr = 2'd1; alu_wr_addr = 4'd5; alu_wr_data = 32'h5555_5555;
      link_thr = '{default: 2'd1}; link_addr = '{default: 4'd5};
      link_wdata = '{default: 32'h6666_6666};
      tick();
      idle();
      peek(0, 2'd1, 4'd5, 32'h2222_0005, "R11 disabled write no effect");

      // R1: reset in the middle of a run clears state
      rst_n = 1'b0;
      peek(2, 2'd0, 4'd5, 32'h0, "R1 mid-run reset");
      tick();
      rst_n = 1'b1;
      tick();
      peek(0, 2'd0, 4'd4, 32'h0, "R1 after second release");

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule